// File: doc/BRIEF.md
# I2C Channel Register and Interrupt Bank

This block is the software-visible register bank for a multi-channel I2C master controller. Each channel has its own function-control, two timing, interrupt-enable, interrupt-status, command/status and byte-buffer registers. A controller-level summary word shows one pending-interrupt bit per channel. The host uses single-cycle register writes. Reads are combinational from the address and have no side effects.

A separate command sequencer per channel does the bit-level bus work. The bank sends it each accepted command word. The sequencer sends back:

- status-set pulses,
- a mask of command bits it has finished,
- its state code,
- the bus-busy flag,
- received bytes.

Clearing the receive-done status with a write-one, while a receive command is still stored, produces a one-cycle `seq_rx_go` pulse. That pulse lets the sequencer fetch the next byte.

Received bytes arrive on a valid/ready stream, one per channel. `rx_ready` is high except in a cycle where the host writes that channel's byte buffer. In that cycle the host write wins. The sequencer must hold `rx_valid` and `rx_byte` until it sees ready.

**Address map.** The address splits into a slot, `reg_addr[ADDR_W-1:6]`, and a byte offset, `reg_addr[5:0]`. Slot 0 is the global region. Slot k (1 ≤ k ≤ NUM_CH) is channel k-1.

**Status, event and command bit positions.**

| Field | Bits |
|---|---|
| Status register | 14:0 |
| Receive-done | bit 2 |
| Master enable | bit 0 |
| Slave enable | bit 1 |
| Receive command | bit 3 |
| Last-receive command | bit 4 |

Top module: `i2c_regbank`

## Requirements
- R1: Channel registers sit at these offsets: function 0x00, timing-A 0x04, timing-B 0x08, enable 0x0C, status 0x10, command 0x14, buffer 0x20. The summary word sits at global offset 0x00. Any other offset, or a slot above NUM_CH, reads 0xFFFFFFFF.
- R2: Writes store the data ANDed with a mask: function 0x0071C3FF, timing-A 0x0FFFFF0F, timing-B 0x00000007, enable 0x00007FFF.
- R3: A function write with bit 1 set is dropped, and the register keeps its old value.
- R4: Writing 1 to a status bit in 14:0 clears it. Writing 0 leaves it unchanged.
- R5: In a cycle with a nonzero `seq_evt_set`, status becomes (status after any clear, OR the event bits) AND enable. The channel's `irq` goes high on the next cycle only if that result is nonzero.
- R6: Summary bit i equals channel i's `irq`. It drops when a status write leaves that channel's status at zero.
- R7: The command register reads:

  | Bits | Content |
  |---|---|
  | 15:0 | stored command |
  | 16 | `seq_bus_busy` |
  | 22:19 | `seq_state` |

  A bit set in `seq_cmd_clr` clears the matching stored command bit.
- R8: A command write is stored only if function bit 0 or bit 1 is set. An accepted write gives a one-cycle `seq_cmd_valid` on the next cycle, with `seq_cmd_data` equal to the written bits 15:0. A rejected write changes nothing.
- R9: A buffer write stores the data's bits 7:0 in bits 7:0 and zero in bits 15:8. An accepted received byte goes to bits 15:8, with zero in bits 7:0. `rx_ready` is low only in a cycle where the host writes that channel's buffer, and the host data is kept.
- R10: `seq_rx_go` pulses for one cycle after a status write that clears a set bit 2 while command bit 3 or 4 is stored. A write to bit 2 that is already clear gives no pulse.
- R11: After reset, every register, the summary, `irq` and all pulse outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Slot and byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| irq | output | NUM_CH | Per-channel interrupt (summary bits) |
| seq_cmd_valid | output | NUM_CH | Accepted command pulse |
| seq_cmd_data | output | 16*NUM_CH | Stored command per channel |
| seq_rx_go | output | NUM_CH | Next-receive pulse |
| seq_evt_set | input | 15*NUM_CH | Status-set pulses from sequencer |
| seq_cmd_clr | input | 16*NUM_CH | Command bits finished by sequencer |
| seq_state | input | 4*NUM_CH | Sequencer state code |
| seq_bus_busy | input | NUM_CH | Bus busy flag |
| rx_valid | input | NUM_CH | Received byte valid |
| rx_ready | output | NUM_CH | Received byte accepted |
| rx_byte | input | 8*NUM_CH | Received byte |

## Verification
The bench builds the bank with NUM_CH=2. With that setting the slot field is two bits wide and slot 3 has no channel, so the out-of-range all-ones read can be reached. Two channels also let the bench show that the summary word carries independent bits for each channel, and that a command written to a disabled channel does not reach the other channel. A behavioural model predicts `irq`, `seq_cmd_valid`, `seq_cmd_data` and `seq_rx_go` on every clock.

// File: rtl/i2c_regbank_pkg.sv
package i2c_regbank_pkg;
  localparam int OFS_W  = 6;
  localparam int DATA_W = 32;
  localparam int STS_W  = 15;
  localparam int CMD_W  = 16;
  localparam int BYTE_W = 8;
  localparam int STA_W  = 4;

  localparam logic [OFS_W-1:0] OFS_FUNC = 6'h00;
  localparam logic [OFS_W-1:0] OFS_TIMA = 6'h04;
  localparam logic [OFS_W-1:0] OFS_TIMB = 6'h08;
  localparam logic [OFS_W-1:0] OFS_IEN  = 6'h0C;
  localparam logic [OFS_W-1:0] OFS_STS  = 6'h10;
  localparam logic [OFS_W-1:0] OFS_CMD  = 6'h14;
  localparam logic [OFS_W-1:0] OFS_BUF  = 6'h20;

  localparam logic [DATA_W-1:0] MSK_FUNC = 32'h0071_C3FF;
  localparam logic [DATA_W-1:0] MSK_TIMA = 32'h0FFF_FF0F;
  localparam logic [DATA_W-1:0] MSK_TIMB = 32'h0000_0007;

  localparam int FN_MASTER  = 0;
  localparam int FN_SLAVE   = 1;
  localparam int ST_RXDONE  = 2;
  localparam int CM_RX      = 3;
  localparam int CM_RXLAST  = 4;
  localparam int RD_BUSY    = 16;
  localparam int RD_STA_LSB = 19;

  typedef enum logic [2:0] {
    SEL_FUNC, SEL_TIMA, SEL_TIMB, SEL_IEN,
    SEL_STS,  SEL_CMD,  SEL_BUF,  SEL_NONE
  } reg_sel_e;

  function automatic reg_sel_e ofs_to_sel(input logic [OFS_W-1:0] o);
    case (o)
      OFS_FUNC: return SEL_FUNC;
      OFS_TIMA: return SEL_TIMA;
      OFS_TIMB: return SEL_TIMB;
      OFS_IEN:  return SEL_IEN;
      OFS_STS:  return SEL_STS;
      OFS_CMD:  return SEL_CMD;
      OFS_BUF:  return SEL_BUF;
      default:  return SEL_NONE;
    endcase
  endfunction
endpackage

// File: rtl/i2c_regbank_decode.sv
module i2c_regbank_decode
  import i2c_regbank_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int SLOT_W = 3,
  localparam int ADDR_W = SLOT_W + OFS_W
) (
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  output logic [NUM_CH-1:0] ch_wr,
  output logic              glob_hit,
  output logic              ch_hit,
  output logic [SLOT_W-1:0] ch_idx,
  output reg_sel_e          sel
);
  localparam logic [SLOT_W:0] LAST_SLOT = (SLOT_W+1)'(NUM_CH);

  logic [SLOT_W-1:0] slot;

  assign slot     = reg_addr[ADDR_W-1:OFS_W];
  assign sel      = ofs_to_sel(reg_addr[OFS_W-1:0]);
  assign glob_hit = (slot == '0);
  assign ch_hit   = (slot != '0) && ({1'b0, slot} <= LAST_SLOT);
  assign ch_idx   = slot - SLOT_W'(1);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_wr
    assign ch_wr[i] = reg_wr && (slot == SLOT_W'(i + 1));
  end
endmodule

// File: rtl/i2c_regbank_chan.sv
module i2c_regbank_chan
  import i2c_regbank_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  reg_sel_e          sel,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq,
  output logic              cmd_valid,
  output logic [CMD_W-1:0]  cmd_data,
  output logic              rx_go,
  input  logic [STS_W-1:0]  evt_set,
  input  logic [CMD_W-1:0]  cmd_clr,
  input  logic [STA_W-1:0]  seq_state,
  input  logic              bus_busy,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [BYTE_W-1:0] rx_byte
);
  logic [DATA_W-1:0]   fn_q, tima_q, timb_q;
  logic [STS_W-1:0]    ien_q, sts_q, sts_d, sts_kept, sts_clr;
  logic                flag_q, flag_d;
  logic [CMD_W-1:0]    cmd_q;
  logic [2*BYTE_W-1:0] buf_q;
  logic                cmdv_q, go_q;
  logic wr_fn, wr_tima, wr_timb, wr_ien, wr_sts, wr_cmd, wr_buf;
  logic raise, cmd_take, rx_pend, go_d, rx_take;

  assign wr_fn   = wr_en && (sel == SEL_FUNC);
  assign wr_tima = wr_en && (sel == SEL_TIMA);
  assign wr_timb = wr_en && (sel == SEL_TIMB);
  assign wr_ien  = wr_en && (sel == SEL_IEN);
  assign wr_sts  = wr_en && (sel == SEL_STS);
  assign wr_cmd  = wr_en && (sel == SEL_CMD);
  assign wr_buf  = wr_en && (sel == SEL_BUF);

  // status: host clear first, then sequencer events, then enable mask
  always_comb begin
    sts_clr  = wr_sts ? wdata[STS_W-1:0] : '0;
    sts_kept = sts_q & ~sts_clr;
    raise    = |evt_set;
    sts_d    = raise ? ((sts_kept | evt_set) & ien_q) : sts_kept;
    flag_d   = flag_q;
    if (raise && (sts_d != '0))       flag_d = 1'b1;
    else if (wr_sts && (sts_d == '0)) flag_d = 1'b0;
  end

  assign cmd_take = wr_cmd && (fn_q[FN_MASTER] || fn_q[FN_SLAVE]);
  assign rx_pend  = cmd_q[CM_RX] || cmd_q[CM_RXLAST];
  assign go_d     = wr_sts && sts_q[ST_RXDONE] && wdata[ST_RXDONE] && rx_pend;
  assign rx_ready = !wr_buf;
  assign rx_take  = rx_valid && rx_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fn_q   <= '0;
      tima_q <= '0;
      timb_q <= '0;
      ien_q  <= '0;
      sts_q  <= '0;
      flag_q <= 1'b0;
      cmd_q  <= '0;
      buf_q  <= '0;
      cmdv_q <= 1'b0;
      go_q   <= 1'b0;
    end else begin
      if (wr_fn && !wdata[FN_SLAVE]) fn_q <= wdata & MSK_FUNC;
      if (wr_tima) tima_q <= wdata & MSK_TIMA;
      if (wr_timb) timb_q <= wdata & MSK_TIMB;
      if (wr_ien)  ien_q  <= wdata[STS_W-1:0];
      sts_q  <= sts_d;
      flag_q <= flag_d;
      if (cmd_take) cmd_q <= wdata[CMD_W-1:0];
      else          cmd_q <= cmd_q & ~cmd_clr;
      if (wr_buf)       buf_q <= {{BYTE_W{1'b0}}, wdata[BYTE_W-1:0]};
      else if (rx_take) buf_q <= {rx_byte, {BYTE_W{1'b0}}};
      cmdv_q <= cmd_take;
      go_q   <= go_d;
    end
  end

  always_comb begin
    rdata = '1;
    case (sel)
      SEL_FUNC: rdata = fn_q;
      SEL_TIMA: rdata = tima_q;
      SEL_TIMB: rdata = timb_q;
      SEL_IEN:  rdata = {{(DATA_W-STS_W){1'b0}}, ien_q};
      SEL_STS:  rdata = {{(DATA_W-STS_W){1'b0}}, sts_q};
      SEL_CMD: begin
        rdata = {{(DATA_W-CMD_W){1'b0}}, cmd_q};
        rdata[RD_BUSY] = bus_busy;
        rdata[RD_STA_LSB +: STA_W] = seq_state;
      end
      SEL_BUF:  rdata = {{(DATA_W-2*BYTE_W){1'b0}}, buf_q};
      default:  rdata = '1;
    endcase
  end

  assign irq       = flag_q;
  assign cmd_valid = cmdv_q;
  assign cmd_data  = cmd_q;
  assign rx_go     = go_q;
endmodule

// File: rtl/i2c_regbank_rdmux.sv
module i2c_regbank_rdmux
  import i2c_regbank_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int SLOT_W = 3
) (
  input  logic                     glob_hit,
  input  logic                     ch_hit,
  input  logic [SLOT_W-1:0]        ch_idx,
  input  reg_sel_e                 sel,
  input  logic [NUM_CH-1:0]        summary,
  input  logic [NUM_CH*DATA_W-1:0] ch_rdata,
  output logic [DATA_W-1:0]        rdata
);
  always_comb begin
    rdata = '1;
    if (glob_hit) begin
      if (sel == SEL_FUNC) begin
        rdata = '0;
        rdata[NUM_CH-1:0] = summary;
      end
    end else if (ch_hit) begin
      for (int i = 0; i < NUM_CH; i++) begin
        if (ch_idx == SLOT_W'(i)) rdata = ch_rdata[i*DATA_W +: DATA_W];
      end
    end
  end
endmodule

// File: rtl/i2c_regbank.sv
module i2c_regbank
  import i2c_regbank_pkg::*;
#(
  parameter int NUM_CH = 4,
  localparam int SLOT_W = $clog2(NUM_CH + 1),
  localparam int ADDR_W = SLOT_W + OFS_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     reg_wr,
  input  logic [ADDR_W-1:0]        reg_addr,
  input  logic [DATA_W-1:0]        reg_wdata,
  output logic [DATA_W-1:0]        reg_rdata,
  output logic [NUM_CH-1:0]        irq,
  output logic [NUM_CH-1:0]        seq_cmd_valid,
  output logic [NUM_CH*CMD_W-1:0]  seq_cmd_data,
  output logic [NUM_CH-1:0]        seq_rx_go,
  input  logic [NUM_CH*STS_W-1:0]  seq_evt_set,
  input  logic [NUM_CH*CMD_W-1:0]  seq_cmd_clr,
  input  logic [NUM_CH*STA_W-1:0]  seq_state,
  input  logic [NUM_CH-1:0]        seq_bus_busy,
  input  logic [NUM_CH-1:0]        rx_valid,
  output logic [NUM_CH-1:0]        rx_ready,
  input  logic [NUM_CH*BYTE_W-1:0] rx_byte
);
  logic [NUM_CH-1:0]        ch_wr;
  logic                     glob_hit, ch_hit;
  logic [SLOT_W-1:0]        ch_idx;
  reg_sel_e                 sel;
  logic [NUM_CH*DATA_W-1:0] ch_rdata;

  i2c_regbank_decode #(.NUM_CH(NUM_CH), .SLOT_W(SLOT_W)) u_dec (
    .reg_wr(reg_wr), .reg_addr(reg_addr), .ch_wr(ch_wr),
    .glob_hit(glob_hit), .ch_hit(ch_hit), .ch_idx(ch_idx), .sel(sel)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    i2c_regbank_chan u_chan (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (ch_wr[i]),
      .sel       (sel),
      .wdata     (reg_wdata),
      .rdata     (ch_rdata[i*DATA_W +: DATA_W]),
      .irq       (irq[i]),
      .cmd_valid (seq_cmd_valid[i]),
      .cmd_data  (seq_cmd_data[i*CMD_W +: CMD_W]),
      .rx_go     (seq_rx_go[i]),
      .evt_set   (seq_evt_set[i*STS_W +: STS_W]),
      .cmd_clr   (seq_cmd_clr[i*CMD_W +: CMD_W]),
      .seq_state (seq_state[i*STA_W +: STA_W]),
      .bus_busy  (seq_bus_busy[i]),
      .rx_valid  (rx_valid[i]),
      .rx_ready  (rx_ready[i]),
      .rx_byte   (rx_byte[i*BYTE_W +: BYTE_W])
    );
  end

  i2c_regbank_rdmux #(.NUM_CH(NUM_CH), .SLOT_W(SLOT_W)) u_rd (
    .glob_hit(glob_hit), .ch_hit(ch_hit), .ch_idx(ch_idx), .sel(sel),
    .summary(irq), .ch_rdata(ch_rdata), .rdata(reg_rdata)
  );
endmodule

// File: rtl/i2c_regbank_chk.sv
module i2c_regbank_chk #(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 9
) (
  input logic                clk,
  input logic                rst_n,
  input logic                reg_wr,
  input logic [ADDR_W-1:0]   reg_addr,
  input logic [31:0]         reg_rdata,
  input logic [NUM_CH-1:0]   irq,
  input logic [NUM_CH-1:0]   seq_cmd_valid,
  input logic [NUM_CH-1:0]   seq_rx_go,
  input logic [NUM_CH*15-1:0] seq_evt_set,
  input logic [NUM_CH-1:0]   rx_ready
);
  AST_GLOBAL_UNMAPPED_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr[ADDR_W-1:6] == '0 && reg_addr[5:0] != 6'h00) |-> reg_rdata == 32'hFFFF_FFFF); // R1

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
    AST_IRQ_RISE_FROM_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq[i]) |-> $past(|seq_evt_set[i*15 +: 15])); // R5
    AST_IRQ_FALL_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq[i]) |-> $past(reg_wr)); // R6
    AST_CMD_PULSE_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      seq_cmd_valid[i] |-> $past(reg_wr)); // R8
    AST_RXGO_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      seq_rx_go[i] |-> $past(reg_wr)); // R10
    AST_READY_LOW_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_ready[i] |-> reg_wr); // R9
  end
endmodule

bind i2c_regbank i2c_regbank_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_rdata(reg_rdata), .irq(irq), .seq_cmd_valid(seq_cmd_valid),
  .seq_rx_go(seq_rx_go), .seq_evt_set(seq_evt_set), .rx_ready(rx_ready)
);

// File: tb/i2c_regbank_tb_top.sv
module i2c_regbank_tb_top;
  localparam int NCH = 2;
  localparam int AW  = $clog2(NCH + 1) + 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic [NCH-1:0] irq, seq_cmd_valid, seq_rx_go, rx_ready;
  logic [NCH*16-1:0] seq_cmd_data;
  logic [NCH*15-1:0] seq_evt_set = '0;
  logic [NCH*16-1:0] seq_cmd_clr = '0;
  logic [NCH*4-1:0]  seq_state = '0;
  logic [NCH-1:0]    seq_bus_busy = '0, rx_valid = '0;
  logic [NCH*8-1:0]  rx_byte = '0;

  int nchk = 0, nerr = 0;
  bit live = 0;

  always #5 clk = ~clk;

  i2c_regbank #(.NUM_CH(NCH)) dut_i (.*);

  // behavioural reference for the per-cycle outputs
  logic [31:0] m_fn[NCH], m_ien[NCH], m_sts[NCH], m_cmd[NCH];
  bit m_irq[NCH], m_cmdv[NCH], m_go[NCH];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NCH; c++) begin
        m_fn[c] = 0; m_ien[c] = 0; m_sts[c] = 0; m_cmd[c] = 0;
        m_irq[c] = 0; m_cmdv[c] = 0; m_go[c] = 0;
      end
    end else begin
      for (int c = 0; c < NCH; c++) begin
        bit sel_c;
        logic [31:0] ev, kept, nxt;
        int ofs;
        sel_c = reg_wr && (int'(reg_addr >> 6) == c + 1);
        ofs = int'(reg_addr[5:0]);
        ev = 32'(seq_evt_set[c*15 +: 15]);
        kept = m_sts[c];
        if (sel_c && ofs == 'h10) kept = kept & ~(reg_wdata & 32'h7FFF);
        nxt = (ev != 0) ? ((kept | ev) & m_ien[c]) : kept;
        m_go[c] = sel_c && ofs == 'h10 && m_sts[c][2] && reg_wdata[2] && (m_cmd[c][3] || m_cmd[c][4]);
        if (ev != 0 && nxt != 0) m_irq[c] = 1;
        else if (sel_c && ofs == 'h10 && nxt == 0) m_irq[c] = 0;
        m_sts[c] = nxt;
        m_cmdv[c] = sel_c && ofs == 'h14 && (m_fn[c][1:0] != 0);
        if (m_cmdv[c]) m_cmd[c] = reg_wdata & 32'hFFFF;
        else m_cmd[c] = m_cmd[c] & ~32'(seq_cmd_clr[c*16 +: 16]);
        if (sel_c && ofs == 'h0C) m_ien[c] = reg_wdata & 32'h7FFF;
        if (sel_c && ofs == 'h00 && !reg_wdata[1]) m_fn[c] = reg_wdata & 32'h0071C3FF;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (live) begin
      for (int c = 0; c < NCH; c++) begin
        chk("R5 irq", 32'(irq[c]), 32'(m_irq[c]));
        chk("R8 cmd_valid", 32'(seq_cmd_valid[c]), 32'(m_cmdv[c]));
        chk("R10 rx_go", 32'(seq_rx_go[c]), 32'(m_go[c]));
        chk("R7 cmd_data", 32'(seq_cmd_data[c*16 +: 16]), m_cmd[c]);
      end
    end
  end

  function automatic logic [AW-1:0] ca(input int ch, input int ofs);
    return AW'(((ch + 1) << 6) | ofs);
  endfunction

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk); reg_addr = a; #1;
    chk(tag, reg_rdata, exp);
  endtask

  task automatic evt(input int c, input logic [14:0] b);
    @(negedge clk); seq_evt_set[c*15 +: 15] = b;
    @(negedge clk); seq_evt_set[c*15 +: 15] = '0;
  endtask

  initial begin
    #2_000_000;
    nerr++;
    $display("FAIL R11 watchdog act=hung exp=done");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1; live = 1;
    // R11 reset state
    rd(ca(0, 'h00), 0, "R11 func");
    rd(ca(0, 'h10), 0, "R11 status");
    rd(ca(0, 'h14), 0, "R11 cmd");
    rd(ca(0, 'h20), 0, "R11 buffer");
    rd(ca(1, 'h0C), 0, "R11 enable");
    rd(0, 0, "R11 summary");
    // R1 unmapped offsets
    rd(ca(0, 'h18), 32'hFFFFFFFF, "R1 ofs18");
    rd(ca(0, 'h1C), 32'hFFFFFFFF, "R1 ofs1C");
    rd(AW'('h04), 32'hFFFFFFFF, "R1 global04");
    rd(AW'(3 << 6), 32'hFFFFFFFF, "R1 slot3");
    // R2 masks
    wr(ca(0, 'h00), 32'hFFFFFFFD); rd(ca(0, 'h00), 32'h0071C3FD, "R2 func");
    wr(ca(0, 'h04), 32'hFFFFFFFF); rd(ca(0, 'h04), 32'h0FFFFF0F, "R2 timA");
    wr(ca(0, 'h08), 32'hFFFFFFFF); rd(ca(0, 'h08), 32'h7, "R2 timB");
    wr(ca(0, 'h0C), 32'hFFFFFFFF); rd(ca(0, 'h0C), 32'h7FFF, "R2 enable");
    // R3 slave enable rejected
    wr(ca(0, 'h00), 32'h2); rd(ca(0, 'h00), 32'h0071C3FD, "R3 func kept");
    // R9 buffer
    wr(ca(0, 'h20), 32'h1234); rd(ca(0, 'h20), 32'h34, "R9 tx byte");
    @(negedge clk); rx_valid[0] = 1; rx_byte[7:0] = 8'hA5; #1;
    chk("R9 ready idle", 32'(rx_ready[0]), 1);
    @(negedge clk); rx_valid[0] = 0;
    rd(ca(0, 'h20), 32'hA500, "R9 rx byte");
    @(negedge clk); reg_wr = 1; reg_addr = ca(0, 'h20); reg_wdata = 32'h77;
    rx_valid[0] = 1; rx_byte[7:0] = 8'h5A; #1;
    chk("R9 ready low", 32'(rx_ready[0]), 0);
    @(negedge clk); reg_wr = 0; rx_valid[0] = 0;
    rd(ca(0, 'h20), 32'h77, "R9 host wins");
    // R5 raise with mask
    wr(ca(0, 'h0C), 32'h5);
    evt(0, 15'h3);
    rd(ca(0, 'h10), 32'h1, "R5 masked status");
    rd(0, 32'h1, "R6 summary set");
    evt(0, 15'h2);
    rd(ca(0, 'h10), 32'h1, "R5 disabled event");
    // R4 write-one clear
    wr(ca(0, 'h10), 32'h0); rd(ca(0, 'h10), 32'h1, "R4 zero keeps");
    wr(ca(0, 'h10), 32'h1); rd(ca(0, 'h10), 32'h0, "R4 one clears");
    rd(0, 32'h0, "R6 summary clear");
    // R8 and R7 command
    wr(ca(0, 'h14), 32'hABCD0009);
    @(negedge clk); seq_bus_busy[0] = 1; seq_state[3:0] = 4'hC;
    rd(ca(0, 'h14), 32'h00610009, "R7 cmd read");
    @(negedge clk); seq_cmd_clr[15:0] = 16'h0001;
    @(negedge clk); seq_cmd_clr[15:0] = 16'h0;
    rd(ca(0, 'h14), 32'h00610008, "R7 cmd clr");
    wr(ca(1, 'h14), 32'h1);
    chk("R8 gated pulse", 32'(seq_cmd_valid[1]), 0);
    rd(ca(1, 'h14), 32'h0, "R8 gated store");
    // R10 next receive
    evt(0, 15'h4);
    wr(ca(0, 'h10), 32'h4);
    chk("R10 go pulse", 32'(seq_rx_go[0]), 1);
    wr(ca(0, 'h10), 32'h4);
    chk("R10 no pulse", 32'(seq_rx_go[0]), 0);
    // R6 per-channel summary
    wr(ca(1, 'h0C), 32'h1);
    evt(1, 15'h1);
    rd(0, 32'h2, "R6 ch1 bit");
    evt(0, 15'h1);
    rd(0, 32'h3, "R6 both bits");
    wr(ca(1, 'h10), 32'h1);
    rd(0, 32'h1, "R6 ch1 cleared");
    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule